// File: doc/BRIEF.md
# PPP Octet-Stuffing Frame Transmitter

This block turns a payload byte stream into the octet stream of an asynchronous-style HDLC/PPP link. It brackets each frame with 7Eh flags. It appends a frame check sequence, which can be 16-bit, 32-bit or left out. It replaces reserved and selected control octets with a two-octet escape pair. While no frame is pending, the line carries continuous 7Eh fill.

If the payload source runs dry before the frame-end marker, the frame is cut with the abort pair 7Dh 7Eh and a one-cycle underrun pulse is raised. A command abort cuts the frame the same way. After an abort, the block keeps sending fill and drains the rest of the aborted frame from the source up to its end marker. The output side uses valid/ready, and the downstream serializer sets the octet pace.

Top module: `ppp_octet_tx`

## Requirements
- R1: With no frame pending the output carries 7Eh on every octet slot, and `in_ready_o` stays low.
- R2: A frame goes out as one opening 7Eh, then the payload octets in order, then the FCS if enabled, then one closing 7Eh. Back-to-back frames are separated by exactly the closing flag of one frame and the opening flag of the next.
- R3: A payload octet v in 00h-1Fh whose bit v of `esc_map_i` is set (bit 0 selects 00h) goes out as 7Dh followed by v XOR 20h. With the bit clear, v goes out unchanged.
- R4: Payload octets 7Dh and 7Eh are always escaped, whatever the map. No other octet from 20h to FFh is escaped.
- R5: With `fcs32_i`=0, the FCS is the bit-reflected CRC-16 (x^16+x^12+x^5+1) with an all-ones preset. It is sent complemented, low octet first, so payload "123456789" ends in 6Eh 90h.
- R6: With `fcs32_i`=1, the FCS is the reflected standard CRC-32 with an all-ones preset. It is sent complemented, low octet first, so payload "123456789" ends in 26h 39h F4h CBh.
- R7: The FCS is computed over the unescaped payload, and its own octets then follow the escape rules of R3 and R4.
- R8: With `fcs_en_i`=0 no FCS is sent. The FCS enable and width are taken when the opening flag is sent and hold for the whole frame.
- R9: If no payload octet is offered at a payload slot before the end marker, the block sends 7Dh 7Eh. `underrun_o` pulses for exactly one cycle, the cycle after the 7Dh is accepted, and 7Eh is on the output during that cycle.
- R10: `abort_i` during a frame replaces the next payload or FCS octet with the pair 7Dh 7Eh, with no underrun pulse. `abort_i` between frames has no effect.
- R11: After an abort the remaining source octets of that frame, up to and including the end marker, are accepted and dropped while 7Eh fill continues. The next frame goes out normally.
- R12: While `out_ready_i` is low the output octet holds, except at a payload slot still waiting for data. No payload octet is accepted without an output transfer, except while dropping after an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| in_data_i | input | 8 | payload octet |
| in_valid_i | input | 1 | payload octet offered |
| in_last_i | input | 1 | octet is the last of its frame |
| in_ready_o | output | 1 | payload octet taken |
| esc_map_i | input | MAP_W | per-character escape select for 00h upward |
| fcs32_i | input | 1 | 1 selects 32-bit FCS, 0 selects 16-bit |
| fcs_en_i | input | 1 | FCS appended when high |
| abort_i | input | 1 | abort the frame in progress |
| out_data_o | output | 8 | line octet |
| out_valid_o | output | 1 | line octet valid (high from the first clock after reset) |
| out_ready_i | input | 1 | line octet accepted |
| underrun_o | output | 1 | one-cycle pulse on a starved frame |

## Verification
Most internal faults here surface within one frame on the output. A wrong CRC register or preset shows up in the FCS octets right after the last payload octet. A lost return state after an escape pair shows up as a missing or extra octet, or as a frame that never closes. Both are caught by comparing whole frames against an independent model, with two fixed check vectors to anchor the CRC. The risk of a latent fault lies in the abort paths. A stale end-of-frame flag shows only on the frame after an abort, as swallowed bytes or a hung source. So every abort test is followed by a normal frame and a check that the source queue has drained.

// File: rtl/ppp_octet_tx_pkg.sv
package ppp_octet_tx_pkg;
  localparam logic [7:0]  FLAG_OCT   = 8'h7E;
  localparam logic [7:0]  ESC_OCT    = 8'h7D;
  localparam logic [7:0]  ESC_FLIP   = 8'h20;
  localparam logic [15:0] CRC16_POLY = 16'h8408;
  localparam logic [31:0] CRC32_POLY = 32'hEDB8_8320;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_ESC,
    ST_FCS,
    ST_CLOSE,
    ST_ABRT,
    ST_DROP
  } tx_st_e;
endpackage

// File: rtl/ppp_octet_tx_crc.sv
module ppp_octet_tx_crc #(
  parameter int         W    = 16,
  parameter logic [W-1:0] POLY = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         upd_i,
  input  logic [7:0]   data_i,
  output logic [W-1:0] fcs_o
);
  logic [W-1:0] crc_q, crc_d;

  // reflected, lsb-first byte update
  always_comb begin
    crc_d = crc_q;
    for (int b = 0; b < 8; b++) begin
      if (crc_d[0] ^ data_i[b]) crc_d = (crc_d >> 1) ^ POLY;
      else                      crc_d = crc_d >> 1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (clr_i)  crc_q <= '1;
    else if (upd_i)  crc_q <= crc_d;
  end

  assign fcs_o = ~crc_q;
endmodule

// File: rtl/ppp_octet_tx_esc.sv
module ppp_octet_tx_esc
  import ppp_octet_tx_pkg::*;
#(
  parameter int MAP_W = 32
) (
  input  logic [7:0]       oct_i,
  input  logic [MAP_W-1:0] map_i,
  output logic             need_o,
  output logic [7:0]       alt_o
);
  localparam int IDX_W = $clog2(MAP_W);

  logic in_map;
  assign in_map = (int'(oct_i) < MAP_W) && map_i[oct_i[IDX_W-1:0]];
  assign need_o = in_map || (oct_i == ESC_OCT) || (oct_i == FLAG_OCT);
  assign alt_o  = oct_i ^ ESC_FLIP;
endmodule

// File: rtl/ppp_octet_tx.sv
module ppp_octet_tx
  import ppp_octet_tx_pkg::*;
#(
  parameter int MAP_W     = 32,
  parameter bit HAS_FCS32 = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       in_data_i,
  input  logic             in_valid_i,
  input  logic             in_last_i,
  output logic             in_ready_o,
  input  logic [MAP_W-1:0] esc_map_i,
  input  logic             fcs32_i,
  input  logic             fcs_en_i,
  input  logic             abort_i,
  output logic [7:0]       out_data_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             underrun_o
);
  localparam int CNT_W = 2;

  tx_st_e st_q, st_d, nxt_q, nxt_d;
  logic [7:0]       pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic eof_q, eof_d, mode32_q, mode32_d, fcs_on_q, fcs_on_d;
  logic abort_req_q, underrun_q, out_valid_q;
  logic xfer, abort_now, in_frame, abort_go, starve, clr, take, in_rdy;
  logic [7:0]  out_oct, d_alt, f_alt, fcs_byte;
  logic        d_need, f_need, fcs_last;
  logic [15:0] fcs16;
  logic [31:0] fcs32, fcs_word;

  assign xfer      = out_valid_q && out_ready_i;
  assign abort_now = abort_i || abort_req_q;
  assign in_frame  = (st_q == ST_DATA) || (st_q == ST_ESC) || (st_q == ST_FCS);

  ppp_octet_tx_crc #(.W(16), .POLY(CRC16_POLY)) i_crc16 (
    .clk_i, .rst_ni, .clr_i(clr), .upd_i(take), .data_i(in_data_i), .fcs_o(fcs16)
  );

  if (HAS_FCS32) begin : g_fcs32
    ppp_octet_tx_crc #(.W(32), .POLY(CRC32_POLY)) i_crc32 (
      .clk_i, .rst_ni, .clr_i(clr), .upd_i(take), .data_i(in_data_i), .fcs_o(fcs32)
    );
  end else begin : g_no_fcs32
    assign fcs32 = '0;
  end

  assign fcs_word = mode32_q ? fcs32 : {16'h0000, fcs16};
  assign fcs_byte = fcs_word[{cnt_q, 3'b000} +: 8];
  assign fcs_last = mode32_q ? (cnt_q == 2'd3) : (cnt_q == 2'd1);

  ppp_octet_tx_esc #(.MAP_W(MAP_W)) i_esc_data (
    .oct_i(in_data_i), .map_i(esc_map_i), .need_o(d_need), .alt_o(d_alt)
  );
  ppp_octet_tx_esc #(.MAP_W(MAP_W)) i_esc_fcs (
    .oct_i(fcs_byte), .map_i(esc_map_i), .need_o(f_need), .alt_o(f_alt)
  );

  always_comb begin
    st_d     = st_q;
    nxt_d    = nxt_q;
    pend_d   = pend_q;
    cnt_d    = cnt_q;
    eof_d    = eof_q;
    mode32_d = mode32_q;
    fcs_on_d = fcs_on_q;
    out_oct  = FLAG_OCT;
    in_rdy   = 1'b0;
    clr      = 1'b0;
    take     = 1'b0;
    abort_go = 1'b0;
    starve   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        // fill octet doubles as opening flag
        if (xfer && in_valid_i) begin
          st_d     = ST_DATA;
          clr      = 1'b1;
          cnt_d    = '0;
          eof_d    = 1'b0;
          mode32_d = fcs32_i && HAS_FCS32;
          fcs_on_d = fcs_en_i;
        end
      end
      ST_DATA: begin
        in_rdy = xfer && !abort_now;
        if (abort_now || !in_valid_i) begin
          out_oct = ESC_OCT;
          if (xfer) begin
            st_d     = ST_ABRT;
            abort_go = 1'b1;
            starve   = !abort_now;
          end
        end else begin
          out_oct = d_need ? ESC_OCT : in_data_i;
          if (xfer) begin
            take  = 1'b1;
            eof_d = in_last_i;
            nxt_d = in_last_i ? (fcs_on_q ? ST_FCS : ST_CLOSE) : ST_DATA;
            if (d_need) begin
              st_d   = ST_ESC;
              pend_d = d_alt;
            end else begin
              st_d   = nxt_d;
            end
          end
        end
      end
      ST_ESC: begin
        out_oct = pend_q;
        if (xfer) st_d = nxt_q;
      end
      ST_FCS: begin
        if (abort_now) begin
          out_oct = ESC_OCT;
          if (xfer) begin
            st_d     = ST_ABRT;
            abort_go = 1'b1;
          end
        end else begin
          out_oct = f_need ? ESC_OCT : fcs_byte;
          if (xfer) begin
            cnt_d = cnt_q + 2'd1;
            nxt_d = fcs_last ? ST_CLOSE : ST_FCS;
            if (f_need) begin
              st_d   = ST_ESC;
              pend_d = f_alt;
            end else begin
              st_d   = nxt_d;
            end
          end
        end
      end
      ST_CLOSE: if (xfer) st_d = ST_IDLE;
      ST_ABRT:  if (xfer) st_d = eof_q ? ST_IDLE : ST_DROP;
      ST_DROP: begin
        in_rdy = 1'b1;
        if (in_valid_i && in_last_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      nxt_q       <= ST_IDLE;
      pend_q      <= '0;
      cnt_q       <= '0;
      eof_q       <= 1'b0;
      mode32_q    <= 1'b0;
      fcs_on_q    <= 1'b0;
      abort_req_q <= 1'b0;
      underrun_q  <= 1'b0;
      out_valid_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      nxt_q       <= nxt_d;
      pend_q      <= pend_d;
      cnt_q       <= cnt_d;
      eof_q       <= eof_d;
      mode32_q    <= mode32_d;
      fcs_on_q    <= fcs_on_d;
      underrun_q  <= starve;
      out_valid_q <= 1'b1;
      if (!in_frame || abort_go) abort_req_q <= 1'b0;
      else if (abort_i)          abort_req_q <= 1'b1;
    end
  end

  assign in_ready_o  = in_rdy;
  assign out_data_o  = out_oct;
  assign out_valid_o = out_valid_q;
  assign underrun_o  = underrun_q;
endmodule

// File: rtl/ppp_octet_tx_chk.sv
module ppp_octet_tx_chk
  import ppp_octet_tx_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] out_data_o,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic       in_ready_o,
  input logic       underrun_o,
  input logic [2:0] st_i
);
  AST_ESC_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_data_o == 8'h7D) |=>
      (out_data_o == 8'h7E || out_data_o == 8'h5D || out_data_o == 8'h5E ||
       out_data_o[7:5] == 3'b001)); // R3
  AST_UR_ON_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> out_data_o == 8'h7E); // R9
  AST_UR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> !underrun_o); // R9
  AST_UR_AFTER_ESC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> ($past(out_data_o) == 8'h7D && $past(out_ready_i))); // R9
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_ready_i && st_i != 3'(ST_DATA)) |=> $stable(out_data_o)); // R12
  AST_NO_BLIND_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && st_i != 3'(ST_DROP)) |-> out_ready_i); // R12
  AST_IDLE_NO_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == 3'(ST_IDLE)) |-> !in_ready_o); // R1
endmodule

bind ppp_octet_tx ppp_octet_tx_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .out_data_o  (out_data_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .in_ready_o  (in_ready_o),
  .underrun_o  (underrun_o),
  .st_i        (st_q)
);

// File: tb/test_ppp_octet_tx.sv
module test_ppp_octet_tx;
  localparam int CLK_P = 10;
  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [31:0] esc_map = '0;
  logic fcs32 = 1'b0, fcs_en = 1'b1, abort = 1'b0;
  logic [7:0] out_data;
  logic out_valid, out_ready = 1'b1, underrun;

  int n_chk = 0, n_bad = 0, ur_cnt = 0, ur_bad = 0, cyc = 0;
  logic [8:0] src_q[$];
  bq_t got_q;
  bit bp_en = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ppp_octet_tx i_ppp_octet_tx (
    .clk_i(clk), .rst_ni(rst_n),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_last_i(in_last), .in_ready_o(in_ready),
    .esc_map_i(esc_map), .fcs32_i(fcs32), .fcs_en_i(fcs_en), .abort_i(abort),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .underrun_o(underrun)
  );

  // source and sink drive
  always @(negedge clk) begin
    cyc++;
    out_ready = !bp_en || (cyc % 3 != 0);
    if (src_q.size() > 0) begin
      in_valid = 1'b1;
      in_data  = src_q[0][7:0];
      in_last  = src_q[0][8];
    end else begin
      in_valid = 1'b0;
      in_last  = 1'b0;
    end
  end

  // sample just before the rising edge
  always begin
    @(negedge clk);
    #(CLK_P/2 - 1);
    if (rst_n) begin
      if (out_valid && out_ready) got_q.push_back(out_data);
      if (in_valid && in_ready) void'(src_q.pop_front());
      if (underrun) begin
        ur_cnt++;
        if (out_data != 8'h7E) ur_bad++;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void push_esc(ref bq_t r, input logic [7:0] b, input logic [31:0] map);
    if (b == 8'h7D || b == 8'h7E || (b < 8'h20 && map[b[4:0]])) begin
      r.push_back(8'h7D);
      r.push_back(b ^ 8'h20);
    end else r.push_back(b);
  endfunction

  function automatic logic [31:0] ref_fcs(bq_t p, bit w32);
    logic [31:0] c, poly;
    logic fb;
    c    = w32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    poly = w32 ? 32'hEDB8_8320 : 32'h0000_8408;
    foreach (p[i])
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ p[i][b];
        c  = c >> 1;
        if (fb) c = c ^ poly;
      end
    c = ~c;
    if (!w32) c[31:16] = '0;
    return c;
  endfunction

  function automatic bq_t model(bq_t p, logic [31:0] map, bit w32, bit en);
    bq_t r;
    logic [31:0] f;
    foreach (p[i]) push_esc(r, p[i], map);
    if (en) begin
      f = ref_fcs(p, w32);
      for (int i = 0; i < (w32 ? 4 : 2); i++) push_esc(r, f[8*i +: 8], map);
    end
    r.push_back(8'h7E);
    return r;
  endfunction

  task automatic load(bq_t p, bit with_last);
    foreach (p[i]) src_q.push_back({with_last && (i == p.size() - 1), p[i]});
  endtask

  task automatic wait_quiet();
    for (int i = 0; i < 2000 && src_q.size() > 0; i++) @(negedge clk);
    repeat (30) @(negedge clk);
  endtask

  task automatic check_frame(string req, bq_t exp);
    int k = 0, bad = 0;
    logic [7:0] a;
    while (k < got_q.size() && got_q[k] == 8'h7E) k++;
    foreach (exp[i]) begin
      a = (k + i < got_q.size()) ? got_q[k + i] : 8'hxx;
      chk(req, {24'h0, a}, {24'h0, exp[i]});
    end
    for (int i = k + exp.size(); i < got_q.size(); i++) if (got_q[i] != 8'h7E) bad++;
    chk({req, " trailing fill"}, bad, 0);
    got_q.delete();
  endtask

  task automatic run_frame(string req, bq_t p, logic [31:0] map, bit w32, bit en);
    @(negedge clk);
    esc_map = map; fcs32 = w32; fcs_en = en;
    got_q.delete();
    load(p, 1'b1);
    wait_quiet();
    check_frame(req, model(p, map, w32, en));
  endtask

  task automatic t_reset();
    int bad = 0;
    repeat (2) @(negedge clk);
    chk("R1 valid after reset", out_valid, 1);
    chk("R1 fill octet", out_data, 8'h7E);
    chk("R1 no take", in_ready, 0);
    chk("R9 no underrun", underrun, 0);
    got_q.delete();
    repeat (10) @(negedge clk);
    foreach (got_q[i]) if (got_q[i] != 8'h7E) bad++;
    chk("R1 idle fill", bad, 0);
    chk("R1 fill count", got_q.size() >= 9, 1);
  endtask

  task automatic t_vectors();
    bq_t p, e16, e32;
    for (int i = 0; i < 9; i++) p.push_back(8'h31 + 8'(i));
    e16 = p; e16.push_back(8'h6E); e16.push_back(8'h90); e16.push_back(8'h7E);
    e32 = p; e32.push_back(8'h26); e32.push_back(8'h39); e32.push_back(8'hF4);
    e32.push_back(8'hCB); e32.push_back(8'h7E);
    @(negedge clk); esc_map = '0; fcs32 = 1'b0; fcs_en = 1'b1; got_q.delete();
    load(p, 1'b1); wait_quiet(); check_frame("R5 crc16 vector", e16);
    @(negedge clk); fcs32 = 1'b1; got_q.delete();
    load(p, 1'b1); wait_quiet(); check_frame("R6 crc32 vector", e32);
  endtask

  task automatic t_escape();
    bq_t p;
    logic [31:0] map;
    map = (32'h1 << 8'h11) | (32'h1 << 8'h13) | 32'h1;
    p = '{8'h00, 8'h05, 8'h11, 8'h7D, 8'h7E, 8'h13, 8'h20, 8'h9A, 8'h3F, 8'h1F, 8'h5D};
    run_frame("R3 R4 mapped and reserved", p, map, 1'b0, 1'b1);
    run_frame("R3 R4 map all ones crc32", p, 32'hFFFF_FFFF, 1'b1, 1'b1);
  endtask

  task automatic t_fcs_esc();
    bq_t p;
    logic [31:0] f;
    int pick = -1;
    for (int k = 0; k < 256 && pick < 0; k++) begin
      p.delete(); p.push_back(k[7:0]);
      f = ref_fcs(p, 1'b0);
      if (f[7:0] < 8'h20 || f[15:8] < 8'h20) pick = k;
    end
    chk("R7 candidate found", pick >= 0, 1);
    run_frame("R7 escaped fcs", p, 32'hFFFF_FFFF, 1'b0, 1'b1);
  endtask

  task automatic t_nofcs();
    bq_t p, e;
    for (int i = 0; i < 8; i++) p.push_back(8'h41 + 8'(i));
    e = p; e.push_back(8'h7E);
    @(negedge clk); esc_map = '0; fcs32 = 1'b0; fcs_en = 1'b0; got_q.delete();
    load(p, 1'b1);
    repeat (3) @(negedge clk);
    fcs_en = 1'b1; fcs32 = 1'b1;
    wait_quiet();
    check_frame("R8 fcs off held for frame", e);
  endtask

  task automatic t_back_to_back();
    bq_t a, b, e, eb;
    a = '{8'h10, 8'h7E, 8'h55};
    b = '{8'hA5, 8'h7D};
    e = model(a, 32'h0001_0000, 1'b0, 1'b1);
    eb = model(b, 32'h0001_0000, 1'b0, 1'b1);
    e.push_back(8'h7E);
    foreach (eb[i]) e.push_back(eb[i]);
    @(negedge clk); esc_map = 32'h0001_0000; fcs32 = 1'b0; fcs_en = 1'b1; got_q.delete();
    load(a, 1'b1); load(b, 1'b1);
    wait_quiet();
    check_frame("R2 back to back", e);
  endtask

  task automatic t_underrun();
    bq_t p, e, rest;
    int ur0;
    p = '{8'hA0, 8'hA1};
    e = '{8'hA0, 8'hA1, 8'h7D, 8'h7E};
    rest = '{8'hB0, 8'hB1, 8'hB2};
    @(negedge clk); esc_map = '0; fcs32 = 1'b0; fcs_en = 1'b1; got_q.delete();
    ur0 = ur_cnt; ur_bad = 0;
    load(p, 1'b0);
    wait_quiet();
    check_frame("R9 underrun abort", e);
    chk("R9 one pulse", ur_cnt - ur0, 1);
    chk("R9 pulse with flag", ur_bad, 0);
    load(rest, 1'b1);
    wait_quiet();
    chk("R11 drained", src_q.size(), 0);
    check_frame("R11 dropped octets", bq_t'{});
    run_frame("R11 next frame", '{8'h01, 8'h02, 8'h03}, '0, 1'b0, 1'b1);
  endtask

  task automatic t_abort();
    bq_t p;
    int k = 0, j, ur0, bad = 0;
    for (int i = 0; i < 40; i++) p.push_back(8'h30 + 8'(i));
    @(negedge clk); esc_map = '0; fcs32 = 1'b0; fcs_en = 1'b1; got_q.delete();
    ur0 = ur_cnt;
    load(p, 1'b1);
    repeat (6) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    wait_quiet();
    while (k < got_q.size() && got_q[k] == 8'h7E) k++;
    j = k;
    while (j < got_q.size() && got_q[j] != 8'h7D) j++;
    chk("R10 abort mid frame", (j - k > 0) && (j - k < 40), 1);
    for (int i = k; i < j; i++) if (got_q[i] != 8'h30 + 8'(i - k)) bad++;
    chk("R10 prefix intact", bad, 0);
    chk("R10 flag after escape", (j + 1 < got_q.size()) ? got_q[j + 1] : 8'h00, 8'h7E);
    bad = 0;
    for (int i = j + 2; i < got_q.size(); i++) if (got_q[i] != 8'h7E) bad++;
    chk("R11 fill after abort", bad, 0);
    chk("R10 no underrun", ur_cnt - ur0, 0);
    chk("R11 rest dropped", src_q.size(), 0);
    got_q.delete();
    run_frame("R11 frame after abort", '{8'hC3, 8'h7E}, '0, 1'b1, 1'b1);
  endtask

  task automatic t_abort_idle();
    int bad = 0;
    @(negedge clk); got_q.delete();
    abort = 1'b1;
    repeat (3) @(negedge clk);
    abort = 1'b0;
    repeat (3) @(negedge clk);
    foreach (got_q[i]) if (got_q[i] != 8'h7E) bad++;
    chk("R10 idle abort ignored", bad, 0);
    run_frame("R10 frame after idle abort", '{8'h11, 8'h22, 8'h33}, '0, 1'b0, 1'b1);
  endtask

  task automatic t_backpressure();
    bq_t p;
    p = '{8'h7D, 8'h02, 8'hEE, 8'h7E, 8'h1B, 8'h80, 8'h00};
    bp_en = 1'b1;
    run_frame("R12 stalled sink", p, 32'h0800_0004, 1'b1, 1'b1);
    run_frame("R12 stalled sink crc16", p, 32'hFFFF_FFFF, 1'b0, 1'b1);
    bp_en = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_vectors();
    t_escape();
    t_fcs_esc();
    t_nofcs();
    t_back_to_back();
    t_underrun();
    t_abort();
    t_abort_idle();
    t_backpressure();
    summary();
    $finish;
  end
endmodule